// File: doc/BRIEF.md
# Halt wake-up controller

This block sits beside the CPU core and decides when a halt ends and how execution continues. When the core executes its halt instruction it presents a mode code, and the controller parks the CPU in one of three low-power modes. These are a light idle mode (IDLE2), a clock-gated idle mode (IDLE1) and a full oscillator stop (STOP). The controller then watches the peripheral interrupt requests, the watchdog request and the USB sub-source requests. It picks the source that ends the halt, and it tells the core to enter interrupt service or to resume at the instruction after the halt.

The choice depends on the winning source's priority level compared with the current interrupt mask. The decision is latched so that a level-sensitive request that drops early is not lost. A wake from STOP first re-enables the oscillator and waits out a programmable warm-up count before the CPU clock runs again. Software can program a per-mode enable set for the peripheral sources. Entry into IDLE1 is refused unless the USB side reports a suspended bus or a stopped USB clock.

Top module: `halt_wake_ctrl`

## Requirements
- R1: A `halt_req` pulse while running, with an accepted mode code, drops `cpu_run` at the next clock edge. The codes are 00 for IDLE2, 01 for IDLE1 and 10 for STOP. The mode is held until the halt ends.
- R2: While halted in IDLE2 or IDLE1, an eligible request seen at a clock edge raises `cpu_run` at that same edge.
- R3: When a halt ends, `svc_pend` is set if the winning level is greater than or equal to `int_mask`, meaning the CPU enters service. Otherwise it is cleared, meaning the CPU resumes after the halt instruction.
- R4: Once set, `svc_pend` stays high until `svc_ack` is sampled high, even if the waking request drops.
- R5: The watchdog request has the fixed level 7. It ends a halt in IDLE2 or IDLE1, always with `svc_pend` set and `wake_src` 0. It is ignored in STOP.
- R6: When several requests are eligible at once, the highest level wins and ties go to the lowest slot. `wake_src` encodes the slots as 0 for the watchdog, 1 for USB, and 2+i for peripheral i.
- R7: Each mode has an enable set for the peripherals, selected by `cfg_mode` (00 IDLE2, 01 IDLE1, 10 STOP, 11 ignored). A `cfg_we` pulse writes `cfg_data` into the selected set. Reset sets all bits to one. A peripheral whose bit is zero cannot end a halt in that mode.
- R8: In STOP, `osc_en` is low and `cpu_run` is low while halted. If an eligible request is seen at edge k, `osc_en` rises at edge k. `cpu_run` rises at edge k+`warm_len`+1.
- R9: USB sub-sources carry the level `usb_lvl`. In IDLE2 any bit of `usb_req` wakes the CPU. In IDLE1 only bits [5:0] (resume, clock-on and bus-reset events) wake it. In STOP none do.
- R10: A halt request with code 11, or with code 01 while both `usb_suspend` and `usb_clkstop` are low, is refused. In that case `cpu_run` stays high and `halt_refused` pulses high for one cycle.
- R11: Reset produces `cpu_run`=1, `osc_en`=1, `svc_pend`=0, `halt_refused`=0 and `wake_src`=0, and all enable sets become all ones. Reset ends any halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Halt instruction executed |
| halt_sel | input | 2 | Requested halt mode code |
| irq_req | input | NUM_SRC | Peripheral interrupt requests |
| irq_lvl | input | NUM_SRC*3 | Peripheral levels, 3 bits each, source i at [3i+2:3i] |
| int_mask | input | 3 | Current interrupt mask level |
| wdt_req | input | 1 | Watchdog (non-maskable) request |
| usb_req | input | USB_N | USB sub-source requests |
| usb_lvl | input | 3 | Level of the USB interrupt |
| usb_suspend | input | 1 | USB bus suspended flag |
| usb_clkstop | input | 1 | USB clock stopped flag |
| warm_len | input | WARM_W | Oscillator warm-up count |
| cfg_we | input | 1 | Enable-set write strobe |
| cfg_mode | input | 2 | Enable set selected for writing |
| cfg_data | input | NUM_SRC | Enable-set write data |
| svc_ack | input | 1 | Core has begun interrupt service |
| cpu_run | output | 1 | CPU clock enabled |
| svc_pend | output | 1 | Service path chosen and not yet acknowledged |
| wake_src | output | IDX_W | Slot that ended the last halt |
| osc_en | output | 1 | Oscillator enable |
| halt_refused | output | 1 | One-cycle pulse for a refused halt |

## Verification
A wrong mode or state register shows up at once at the ports. Either `cpu_run` fails to rise in the cycle the model expects, or `osc_en` is low outside a STOP halt. A corrupted winner or level comparison appears in `wake_src` or `svc_pend` in the cycle right after the waking edge. A warm-up count off by one moves the rise of `cpu_run` by a cycle. Because the bench compares every output against its model on every clock, each of these errors is caught in the first cycle where it differs.

// File: rtl/hwk_pkg.sv
package hwk_pkg;

    localparam int LVL_W = 3;
    localparam logic [LVL_W-1:0] NMI_LEVEL = 3'd7;

    typedef enum logic [1:0] {
        HM_IDLE2 = 2'b00,
        HM_IDLE1 = 2'b01,
        HM_STOP  = 2'b10,
        HM_BAD   = 2'b11
    } halt_mode_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_WARM = 2'd2
    } wake_state_e;

    typedef struct packed {
        logic             hit;
        logic [LVL_W-1:0] lvl;
    } pick_res_t;

    // A halt request is accepted for IDLE2 and STOP, and for IDLE1 only
    // while the USB side reports suspend or a stopped clock.
    function automatic logic mode_accepted(halt_mode_e m, logic susp, logic cstop);
        return (m == HM_IDLE2) || (m == HM_STOP) ||
               ((m == HM_IDLE1) && (susp || cstop));
    endfunction

endpackage

// File: rtl/hwk_mask_bank.sv
module hwk_mask_bank #(
    parameter int NUM_SRC = 8,
    parameter int NMODE   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         wr_mode,
    input  logic [NUM_SRC-1:0] wr_data,
    input  logic [1:0]         rd_mode,
    output logic [NUM_SRC-1:0] rd_vec
);

    logic [NUM_SRC-1:0] bank [NMODE];

    for (genvar g = 0; g < NMODE; g++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst)
                bank[g] <= '1;
            else if (wr_en && (wr_mode == 2'(g)))
                bank[g] <= wr_data;
        end
    end

    always_comb begin
        rd_vec = '0;
        for (int m = 0; m < NMODE; m++)
            if (rd_mode == 2'(m))
                rd_vec = bank[m];
    end

endmodule

// File: rtl/hwk_pick.sv
module hwk_pick
    import hwk_pkg::*;
#(
    parameter int NSLOT = 10,
    parameter int IDX_W = 4
) (
    input  logic [NSLOT-1:0]       req,
    input  logic [NSLOT*LVL_W-1:0] lvl,
    output pick_res_t              res,
    output logic [IDX_W-1:0]       idx
);

    // Strictly-greater update keeps the lowest slot on equal levels.
    always_comb begin
        res = '0;
        idx = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (req[s] && (!res.hit || (lvl[s*LVL_W +: LVL_W] > res.lvl))) begin
                res.hit = 1'b1;
                res.lvl = lvl[s*LVL_W +: LVL_W];
                idx     = IDX_W'(s);
            end
        end
    end

endmodule

// File: rtl/hwk_warmup.sv
module hwk_warmup #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;
    logic             act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            act_q <= 1'b1;
            cnt_q <= len;
        end else if (act_q) begin
            if (cnt_q == '0)
                act_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = act_q && (cnt_q == '0);

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import hwk_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int WARM_W  = 16,
    parameter int USB_N   = 24,
    parameter logic [USB_N-1:0] USB_IDLE1_SET = 'h3F,
    localparam int NSLOT  = NUM_SRC + 2,
    localparam int IDX_W  = $clog2(NSLOT)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     halt_req,
    input  logic [1:0]               halt_sel,
    input  logic [NUM_SRC-1:0]       irq_req,
    input  logic [NUM_SRC*LVL_W-1:0] irq_lvl,
    input  logic [LVL_W-1:0]         int_mask,
    input  logic                     wdt_req,
    input  logic [USB_N-1:0]         usb_req,
    input  logic [LVL_W-1:0]         usb_lvl,
    input  logic                     usb_suspend,
    input  logic                     usb_clkstop,
    input  logic [WARM_W-1:0]        warm_len,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_mode,
    input  logic [NUM_SRC-1:0]       cfg_data,
    input  logic                     svc_ack,
    output logic                     cpu_run,
    output logic                     svc_pend,
    output logic [IDX_W-1:0]         wake_src,
    output logic                     osc_en,
    output logic                     halt_refused
);

    wake_state_e state_q, state_d;
    halt_mode_e  mode_q, mode_d;
    halt_mode_e  sel_mode;
    logic        refuse_d;
    logic        warm_start;
    logic        warm_done;
    logic        usb_hit;
    logic        wake_now;

    logic [NUM_SRC-1:0]     en_vec;
    logic [NSLOT-1:0]       slot_req;
    logic [NSLOT*LVL_W-1:0] slot_lvl;
    pick_res_t              pick;
    logic [IDX_W-1:0]       pick_idx;

    assign sel_mode = halt_mode_e'(halt_sel);

    hwk_mask_bank #(.NUM_SRC(NUM_SRC), .NMODE(3)) u_masks (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_mode (cfg_mode),
        .wr_data (cfg_data),
        .rd_mode (mode_q),
        .rd_vec  (en_vec)
    );

    // USB sub-source filtering per mode
    always_comb begin
        unique case (mode_q)
            HM_IDLE2: usb_hit = |usb_req;
            HM_IDLE1: usb_hit = |(usb_req & USB_IDLE1_SET);
            default:  usb_hit = 1'b0;
        endcase
    end

    // Slot 0: watchdog, slot 1: USB, slots 2.. : peripherals
    assign slot_req[0]               = wdt_req && (mode_q != HM_STOP);
    assign slot_lvl[0 +: LVL_W]      = NMI_LEVEL;
    assign slot_req[1]               = usb_hit;
    assign slot_lvl[LVL_W +: LVL_W]  = usb_lvl;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_periph
        assign slot_req[g+2]                 = irq_req[g] && en_vec[g];
        assign slot_lvl[(g+2)*LVL_W +: LVL_W] = irq_lvl[g*LVL_W +: LVL_W];
    end

    hwk_pick #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_pick (
        .req (slot_req),
        .lvl (slot_lvl),
        .res (pick),
        .idx (pick_idx)
    );

    hwk_warmup #(.CNT_W(WARM_W)) u_warm (
        .clk   (clk),
        .rst   (rst),
        .start (warm_start),
        .len   (warm_len),
        .done  (warm_done)
    );

    assign wake_now = (state_q == ST_HALT) && pick.hit;

    always_comb begin
        state_d    = state_q;
        mode_d     = mode_q;
        refuse_d   = 1'b0;
        warm_start = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (halt_req) begin
                    if (mode_accepted(sel_mode, usb_suspend, usb_clkstop)) begin
                        state_d = ST_HALT;
                        mode_d  = sel_mode;
                    end else begin
                        refuse_d = 1'b1;
                    end
                end
            end
            ST_HALT: begin
                if (pick.hit) begin
                    if (mode_q == HM_STOP) begin
                        state_d    = ST_WARM;
                        warm_start = 1'b1;
                    end else begin
                        state_d = ST_RUN;
                    end
                end
            end
            ST_WARM: begin
                if (warm_done)
                    state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_RUN;
            mode_q       <= HM_IDLE2;
            halt_refused <= 1'b0;
            svc_pend     <= 1'b0;
            wake_src     <= '0;
        end else begin
            state_q      <= state_d;
            mode_q       <= mode_d;
            halt_refused <= refuse_d;
            if (wake_now) begin
                svc_pend <= (pick.lvl >= int_mask);
                wake_src <= pick_idx;
            end else if (svc_ack) begin
                svc_pend <= 1'b0;
            end
        end
    end

    assign cpu_run = (state_q == ST_RUN);
    assign osc_en  = !((state_q == ST_HALT) && (mode_q == HM_STOP));

endmodule

// File: rtl/hwk_checker.sv
module hwk_checker #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             halt_req,
    input logic [1:0]       halt_sel,
    input logic             usb_suspend,
    input logic             usb_clkstop,
    input logic             wdt_req,
    input logic             svc_ack,
    input logic             cpu_run,
    input logic             svc_pend,
    input logic [IDX_W-1:0] wake_src,
    input logic             osc_en,
    input logic             halt_refused,
    input logic [1:0]       st,
    input logic [1:0]       md
);

    logic sel_ok;
    assign sel_ok = (halt_sel == 2'b00) || (halt_sel == 2'b10) ||
                    ((halt_sel == 2'b01) && (usb_suspend || usb_clkstop));

    p_reset_state_r11: assert property (@(posedge clk)
        rst |=> (cpu_run && osc_en && !svc_pend && !halt_refused));

    p_enter_halt_r1: assert property (@(posedge clk) disable iff (rst)
        (st == 2'd0 && halt_req && sel_ok) |=> !cpu_run);

    p_refuse_r10: assert property (@(posedge clk) disable iff (rst)
        (st == 2'd0 && halt_req && !sel_ok) |=> (cpu_run && halt_refused));

    p_svc_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (svc_pend && !svc_ack && st != 2'd1) |=> svc_pend);

    p_wdt_service_r5: assert property (@(posedge clk) disable iff (rst)
        (st == 2'd1 && md != 2'b10 && wdt_req) |=> (svc_pend && wake_src == '0 && cpu_run));

    p_osc_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> !cpu_run);

    p_warm_wait_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_en) |-> !cpu_run);

endmodule

bind halt_wake_ctrl hwk_checker #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .halt_req     (halt_req),
    .halt_sel     (halt_sel),
    .usb_suspend  (usb_suspend),
    .usb_clkstop  (usb_clkstop),
    .wdt_req      (wdt_req),
    .svc_ack      (svc_ack),
    .cpu_run      (cpu_run),
    .svc_pend     (svc_pend),
    .wake_src     (wake_src),
    .osc_en       (osc_en),
    .halt_refused (halt_refused),
    .st           (state_q),
    .md           (mode_q)
);

// File: tb/test_halt_wake_ctrl.sv
module test_halt_wake_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NS   = 8;
    localparam int WW   = 16;
    localparam int UN   = 24;
    localparam int NSL  = NS + 2;
    localparam int IW   = $clog2(NSL);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt_req = 0;
    logic [1:0] halt_sel = 0;
    logic [NS-1:0] irq_req = 0;
    logic [NS*3-1:0] irq_lvl = 0;
    logic [2:0] int_mask = 0;
    logic wdt_req = 0;
    logic [UN-1:0] usb_req = 0;
    logic [2:0] usb_lvl = 0;
    logic usb_suspend = 0;
    logic usb_clkstop = 0;
    logic [WW-1:0] warm_len = 0;
    logic cfg_we = 0;
    logic [1:0] cfg_mode = 0;
    logic [NS-1:0] cfg_data = 0;
    logic svc_ack = 0;
    logic cpu_run, svc_pend, osc_en, halt_refused;
    logic [IW-1:0] wake_src;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    halt_wake_ctrl #(.NUM_SRC(NS), .WARM_W(WW), .USB_N(UN)) i_halt_wake_ctrl (
        .clk(clk), .rst(rst), .halt_req(halt_req), .halt_sel(halt_sel),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .int_mask(int_mask),
        .wdt_req(wdt_req), .usb_req(usb_req), .usb_lvl(usb_lvl),
        .usb_suspend(usb_suspend), .usb_clkstop(usb_clkstop),
        .warm_len(warm_len), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_data(cfg_data), .svc_ack(svc_ack), .cpu_run(cpu_run),
        .svc_pend(svc_pend), .wake_src(wake_src), .osc_en(osc_en),
        .halt_refused(halt_refused)
    );

    // ---------------- behavioural reference ----------------
    int m_state;   // 0 running, 1 halted, 2 warming
    int m_mode, m_svc, m_src, m_ref, m_cnt;
    int m_en [3][NS];

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_state = 0; m_mode = 0; m_svc = 0; m_src = 0; m_ref = 0; m_cnt = 0;
            for (int m = 0; m < 3; m++)
                for (int i = 0; i < NS; i++) m_en[m][i] = 1;
        end else begin
            int best, blvl;
            best = -1; blvl = -1;
            m_ref = 0;
            if (m_state == 1) begin
                for (int s = 0; s < NSL; s++) begin
                    int r, l;
                    if (s == 0) begin
                        r = (wdt_req && m_mode != 2) ? 1 : 0; l = 7;
                    end else if (s == 1) begin
                        if (m_mode == 0) r = (usb_req != 0) ? 1 : 0;
                        else if (m_mode == 1) r = (usb_req[5:0] != 0) ? 1 : 0;
                        else r = 0;
                        l = usb_lvl;
                    end else begin
                        r = (irq_req[s-2] && m_en[m_mode][s-2] == 1) ? 1 : 0;
                        l = irq_lvl[(s-2)*3 +: 3];
                    end
                    if (r == 1 && l > blvl) begin best = s; blvl = l; end
                end
            end
            if (svc_ack) m_svc = 0;
            case (m_state)
                0: if (halt_req) begin
                       if (halt_sel == 3 || (halt_sel == 1 && !usb_suspend && !usb_clkstop))
                           m_ref = 1;
                       else begin m_state = 1; m_mode = halt_sel; end
                   end
                1: if (best >= 0) begin
                       m_src = best;
                       m_svc = (blvl >= int_mask) ? 1 : 0;
                       if (m_mode == 2) begin m_state = 2; m_cnt = warm_len; end
                       else m_state = 0;
                   end
                default: if (m_cnt == 0) m_state = 0; else m_cnt--;
            endcase
            if (cfg_we && cfg_mode != 3)
                for (int i = 0; i < NS; i++) m_en[cfg_mode][i] = cfg_data[i];
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            check("R1 model cpu_run", cpu_run, (m_state == 0) ? 1 : 0);
            check("R3 model svc_pend", svc_pend, m_svc);
            check("R6 model wake_src", wake_src, m_src);
            check("R8 model osc_en", osc_en, (m_state == 1 && m_mode == 2) ? 0 : 1);
            check("R10 model halt_refused", halt_refused, m_ref);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_halt(input int code);
        halt_sel = 2'(code);
        halt_req = 1'b1;
        cyc(1);
        halt_req = 1'b0;
    endtask

    task automatic set_lvl(input int i, input int l);
        irq_lvl[i*3 +: 3] = 3'(l);
    endtask

    task automatic ack();
        svc_ack = 1'b1;
        cyc(1);
        svc_ack = 1'b0;
    endtask

    task automatic summary();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired, actual=hung expected=done");
            summary();
        end
    end

    initial begin
        cyc(3);
        // R11 reset state
        check("R11 reset cpu_run", cpu_run, 1);
        check("R11 reset osc_en", osc_en, 1);
        check("R11 reset svc_pend", svc_pend, 0);
        check("R11 reset wake_src", wake_src, 0);
        rst = 1'b0;
        cyc(1);

        // R1/R2/R3 service wake from IDLE2, R4 hold
        set_lvl(3, 5); int_mask = 3;
        do_halt(0);
        check("R1 halted", cpu_run, 0);
        cyc(2);
        irq_req[3] = 1'b1;
        cyc(1);
        check("R2 idle wake run", cpu_run, 1);
        check("R3 service chosen", svc_pend, 1);
        check("R6 src periph3", wake_src, 5);
        irq_req[3] = 1'b0;
        cyc(3);
        check("R4 svc held after drop", svc_pend, 1);
        ack();
        check("R4 svc cleared by ack", svc_pend, 0);

        // R3 resume path
        set_lvl(3, 2); int_mask = 4;
        do_halt(0);
        irq_req[3] = 1'b1;
        cyc(1);
        irq_req[3] = 1'b0;
        check("R3 resume run", cpu_run, 1);
        check("R3 resume no service", svc_pend, 0);

        // R10 refused halts
        do_halt(1);
        check("R10 idle1 refused run", cpu_run, 1);
        check("R10 refused pulse", halt_refused, 1);
        cyc(1);
        check("R10 pulse one cycle", halt_refused, 0);
        do_halt(3);
        check("R10 code11 refused", halt_refused, 1);

        // R9 USB filtering in IDLE1
        usb_suspend = 1'b1;
        do_halt(1);
        usb_req = 24'h000400; usb_lvl = 1;
        cyc(3);
        check("R9 filtered usb ignored", cpu_run, 0);
        usb_req = 24'h000004;
        cyc(1);
        usb_req = 0;
        check("R9 usb reset-start wakes", cpu_run, 1);
        check("R9 usb src", wake_src, 1);
        check("R3 usb resume", svc_pend, 0);

        // R9 IDLE2 accepts any USB bit
        do_halt(0);
        usb_req = 24'h800000; usb_lvl = 6;
        cyc(1);
        usb_req = 0;
        check("R9 idle2 any usb", cpu_run, 1);
        check("R3 usb service", svc_pend, 1);
        ack();

        // R6 simultaneous requests
        int_mask = 6;
        set_lvl(1, 4); set_lvl(6, 6); set_lvl(2, 6);
        do_halt(0);
        irq_req = 8'b0100_0110;
        cyc(1);
        irq_req = 0;
        check("R6 tie lowest index", wake_src, 4);
        check("R6 winner service", svc_pend, 1);
        ack();

        // R5 watchdog in IDLE1 with highest mask
        int_mask = 7;
        do_halt(1);
        wdt_req = 1'b1;
        cyc(1);
        wdt_req = 1'b0;
        check("R5 wdt wake", cpu_run, 1);
        check("R5 wdt service", svc_pend, 1);
        check("R5 wdt src", wake_src, 0);
        ack();

        // R8 STOP warm-up of 5
        warm_len = 5; set_lvl(0, 3); int_mask = 2;
        do_halt(2);
        check("R8 stop osc off", osc_en, 0);
        irq_req[0] = 1'b1;
        cyc(1);
        irq_req[0] = 1'b0;
        check("R8 osc on at wake", osc_en, 1);
        check("R8 still halted", cpu_run, 0);
        cyc(5);
        check("R8 warm not done", cpu_run, 0);
        cyc(1);
        check("R8 run after warm", cpu_run, 1);
        ack();

        // R5 watchdog ignored in STOP
        warm_len = 2; int_mask = 7; set_lvl(4, 1);
        do_halt(2);
        wdt_req = 1'b1;
        cyc(4);
        check("R5 wdt ignored in stop", cpu_run, 0);
        check("R5 osc stays off", osc_en, 0);
        wdt_req = 1'b0;
        irq_req[4] = 1'b1;
        cyc(1);
        irq_req[4] = 1'b0;
        cyc(3);
        check("R8 run after warm 2", cpu_run, 1);
        check("R3 stop resume", svc_pend, 0);

        // R7 per-mode enable set
        cfg_mode = 0; cfg_data = 8'hFE; cfg_we = 1'b1;
        cyc(1);
        cfg_we = 1'b0;
        set_lvl(0, 7); set_lvl(1, 2); int_mask = 1;
        do_halt(0);
        irq_req[0] = 1'b1;
        cyc(3);
        check("R7 disabled source ignored", cpu_run, 0);
        irq_req[1] = 1'b1;
        cyc(1);
        irq_req = 0;
        check("R7 enabled source wakes", cpu_run, 1);
        check("R7 disabled not winner", wake_src, 3);
        ack();

        // R11 reset ends halt and restores enable sets
        do_halt(0);
        rst = 1'b1;
        cyc(1);
        rst = 1'b0;
        check("R11 reset ends halt", cpu_run, 1);
        do_halt(0);
        irq_req[0] = 1'b1;
        cyc(1);
        irq_req = 0;
        check("R11 mask restored", wake_src, 2);
        cyc(2);
        summary();
    end

endmodule